// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Software Command Port

This block holds the main page-translation entries of a memory-management unit. Entries sit in a set-associative array; the set is picked by the low bits of the virtual page number and the way by either a search or a replacement choice. Software maintains the array through four registers written over a small register port: a virtual-side descriptor (page number, address-space ID, global and valid flags), a physical-side descriptor (frame number and permission bits), an index register, and a command register. Every command runs in a fixed two cycles, during which a busy flag is raised and further register writes are dropped.

Commands cover searching for a descriptor, asking the block for a slot to fill, storing an entry (with or without a pulse that tells the small per-pipeline translation caches to drop their contents), reading an entry back, and issuing that drop pulse on its own. In parallel, the pipeline can present a virtual page and the current address-space ID to a lookup port and receive a registered hit, frame and permission result one cycle later.

Top module: `xlat_jtlb`

## Requirements
- R1: An entry's linear index is set × WAYS + way, where the set is the low log2(SETS) bits of the virtual page number. The virtual descriptor holds the page number in bits [31:13], the valid flag in bit 9, the global flag in bit 8 and the address-space ID in bits [7:0]; the physical descriptor holds the frame number in bits [31:13] and the permission bits in [5:0].
- R2: The search command (code 1) compares the virtual descriptor against every way of its set; when exactly one way matches, the index register receives that entry's linear index.
- R3: A search that matches no way leaves 0x8000_0000 in the index register; a search that matches two or more ways leaves 0xC000_0000.
- R4: The slot command (code 2) writes into the index register the linear index of the lowest-numbered invalid way in the set addressed by the virtual descriptor.
- R5: When every way of that set is valid, the slot command returns the set's own round-robin pointer (0 after reset) and advances that pointer by one, wrapping; other sets' pointers are unaffected.
- R6: The store command (code 3) writes both descriptors to the entry named by the index register and pulses the micro-cache drop output for one cycle; the quiet store command (code 4) writes the same way with no pulse.
- R7: The read command (code 5) loads both descriptor registers from the entry named by the index register.
- R8: An entry matches only when its valid flag is set; storing all-zero descriptors leaves an entry that no search or lookup can hit.
- R9: An entry with the global flag matches any address-space ID; any other entry matches only its own 8-bit ID.
- R10: The drop command (code 6) pulses the micro-cache drop output for one cycle and changes no entry.
- R11: Register selects are 0 virtual descriptor, 1 physical descriptor, 2 index, 3 command. A command write raises busy for exactly two cycles, after which results are visible; any register write offered while busy is ignored. Reset clears all registers and entries and drops busy.
- R12: A lookup request returns, one cycle later, hit plus the frame and permissions of the lowest-numbered matching way of the request's set, using the current address-space ID given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | 32 | Register write data |
| pd0_o | output | 32 | Virtual descriptor register |
| pd1_o | output | 32 | Physical descriptor register |
| index_o | output | 32 | Index register (with error codes) |
| busy_o | output | 1 | Command in progress |
| utlb_flush_o | output | 1 | One-cycle micro-cache drop pulse |
| lk_req_i | input | 1 | Pipeline lookup request |
| lk_vpn_i | input | 19 | Lookup virtual page number |
| lk_asid_i | input | 8 | Current address-space ID |
| lk_hit_o | output | 1 | Registered lookup hit |
| lk_pfn_o | output | 19 | Registered frame number |
| lk_perm_o | output | 6 | Registered permission bits |

## Verification
The bench fills a small eight-set, four-way instance slot by slot through search and slot commands, so an off-by-one in set or way indexing shows up as wrong indices and mismatched read-back. It forces a full set to expose a replacement pointer that never advances or is shared between sets, plants two matching entries to catch a design that reports the first hit instead of the duplicate code, and checks that global entries hit under a foreign ID while private ones do not. It also offers commands while busy, where a design that accepted them would emit a stray drop pulse, and erases an entry with zero descriptors, where a design that ignored the valid flag would still hit.

// File: rtl/xlat_jtlb_pkg.sv
package xlat_jtlb_pkg;

    localparam int REG_W   = 32;
    localparam int VPN_W   = 19;
    localparam int PFN_W   = 19;
    localparam int PERM_W  = 6;
    localparam int ASID_W  = 8;
    localparam int VLD_BIT = 9;
    localparam int GLB_BIT = 8;

    localparam logic [REG_W-1:0] IDX_MISS = 32'h8000_0000;
    localparam logic [REG_W-1:0] IDX_DUP  = 32'hC000_0000;

    localparam logic [1:0] SEL_PD0 = 2'd0;
    localparam logic [1:0] SEL_PD1 = 2'd1;
    localparam logic [1:0] SEL_IDX = 2'd2;
    localparam logic [1:0] SEL_CMD = 2'd3;

    typedef enum logic [2:0] {
        C_NOP      = 3'd0,
        C_PROBE    = 3'd1,
        C_GETIDX   = 3'd2,
        C_WRITE    = 3'd3,
        C_WRITE_NI = 3'd4,
        C_READ     = 3'd5,
        C_IVU      = 3'd6
    } tlb_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SRCH = 2'd1,
        PH_DONE = 2'd2
    } tlb_phase_e;

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;

    function automatic logic ent_hit(input tlb_ent_t e,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic [ASID_W-1:0] asid);
        return e.vld && (e.vpn == vpn) && (e.glb || (e.asid == asid));
    endfunction

    function automatic logic [REG_W-1:0] pd0_pack(input tlb_ent_t e);
        logic [REG_W-1:0] r;
        r = '0;
        r[REG_W-1 -: VPN_W] = e.vpn;
        r[VLD_BIT]          = e.vld;
        r[GLB_BIT]          = e.glb;
        r[ASID_W-1:0]       = e.asid;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pd1_pack(input tlb_ent_t e);
        logic [REG_W-1:0] r;
        r = '0;
        r[REG_W-1 -: PFN_W] = e.pfn;
        r[PERM_W-1:0]       = e.perm;
        return r;
    endfunction

endpackage

// File: rtl/xlat_jtlb_store.sv
module xlat_jtlb_store
    import xlat_jtlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WB    = $clog2(WAYS),
    localparam int IDX_W = SET_W + WB,
    localparam int ENTRIES = SETS * WAYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic [IDX_W-1:0]  rd_idx,
    output tlb_ent_t          rd_ent,
    input  logic [SET_W-1:0]  pr_set,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    output logic [WAYS-1:0]   pr_hit,
    output logic [WAYS-1:0]   pr_vld,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_any,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm
);

    tlb_ent_t ents [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = ents[rd_idx];

    logic [WAYS-1:0]   lk_hv;
    logic [PFN_W-1:0]  lk_pfn_w  [WAYS];
    logic [PERM_W-1:0] lk_perm_w [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WB-1:0] WL = WB'(w);
        logic [IDX_W-1:0] ix_p, ix_l;
        assign ix_p = {pr_set, WL};
        assign ix_l = {lk_set, WL};
        assign pr_hit[w]    = ent_hit(ents[ix_p], pr_vpn, pr_asid);
        assign pr_vld[w]    = ents[ix_p].vld;
        assign lk_hv[w]     = ent_hit(ents[ix_l], lk_vpn, lk_asid);
        assign lk_pfn_w[w]  = ents[ix_l].pfn;
        assign lk_perm_w[w] = ents[ix_l].perm;
    end

    always_comb begin
        lk_any  = |lk_hv;
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (lk_hv[i]) begin
                lk_pfn  = lk_pfn_w[i];
                lk_perm = lk_perm_w[i];
            end
        end
    end

    // a store lands exactly where it was aimed (R6)
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ents[$past(wr_idx)] == $past(wr_ent));

endmodule

// File: rtl/xlat_jtlb_victim.sv
module xlat_jtlb_victim #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WB    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic [WAYS-1:0]  vld_i,
    input  logic             take_i,
    output logic [WB-1:0]    way_o
);

    logic [WB-1:0] rr [SETS];
    logic          full;
    logic [WB-1:0] free_way;

    always_comb begin
        full     = &vld_i;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld_i[i]) free_way = WB'(i);
        end
    end

    assign way_o = full ? rr[set_i] : free_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) rr[s] <= '0;
        end else if (take_i && full) begin
            rr[set_i] <= rr[set_i] + WB'(1);
        end
    end

    // a full-set choice steps that set's pointer by one (R5)
    assert_rr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (take_i && full) |=> rr[$past(set_i)] == WB'($past(rr[set_i]) + WB'(1)));

    // a set with a free way never hands out a valid way (R4)
    assert_free_first_R4: assert property (@(posedge clk) disable iff (rst)
        (take_i && !full) |-> !vld_i[way_o]);

endmodule

// File: rtl/xlat_jtlb.sv
module xlat_jtlb
    import xlat_jtlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       pd0_o,
    output logic [31:0]       pd1_o,
    output logic [31:0]       index_o,
    output logic              busy_o,
    output logic              utlb_flush_o,
    input  logic              lk_req_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              lk_hit_o,
    output logic [PFN_W-1:0]  lk_pfn_o,
    output logic [PERM_W-1:0] lk_perm_o
);

    localparam int SET_W   = $clog2(SETS);
    localparam int WB      = $clog2(WAYS);
    localparam int IDX_W   = SET_W + WB;
    localparam int ENTRIES = SETS * WAYS;

    tlb_phase_e       phase;
    tlb_cmd_e         cmd_q;
    logic [REG_W-1:0] pd0_q, pd1_q, idx_q;
    logic [WAYS-1:0]  hit_q, vld_q;
    logic             flush_q;

    logic [VPN_W-1:0]  cur_vpn;
    logic [SET_W-1:0]  cur_set;
    logic [ASID_W-1:0] cur_asid;
    tlb_ent_t          new_ent, rd_ent;
    logic [WAYS-1:0]   pr_hit, pr_vld;
    logic              st_wr;
    logic [WB-1:0]     vic_way, hit_way;
    logic              take;
    logic              lk_any;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PERM_W-1:0] lk_perm;

    assign cur_vpn  = pd0_q[REG_W-1 -: VPN_W];
    assign cur_set  = cur_vpn[SET_W-1:0];
    assign cur_asid = pd0_q[ASID_W-1:0];

    always_comb begin
        new_ent      = '0;
        new_ent.vld  = pd0_q[VLD_BIT];
        new_ent.glb  = pd0_q[GLB_BIT];
        new_ent.asid = cur_asid;
        new_ent.vpn  = cur_vpn;
        new_ent.pfn  = pd1_q[REG_W-1 -: PFN_W];
        new_ent.perm = pd1_q[PERM_W-1:0];
    end

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_q[i]) hit_way = WB'(i);
        end
    end

    assign st_wr = (phase == PH_DONE) && ((cmd_q == C_WRITE) || (cmd_q == C_WRITE_NI));
    assign take  = (phase == PH_DONE) && (cmd_q == C_GETIDX);

    xlat_jtlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st_wr),
        .wr_idx  (idx_q[IDX_W-1:0]),
        .wr_ent  (new_ent),
        .rd_idx  (idx_q[IDX_W-1:0]),
        .rd_ent  (rd_ent),
        .pr_set  (cur_set),
        .pr_vpn  (cur_vpn),
        .pr_asid (cur_asid),
        .pr_hit  (pr_hit),
        .pr_vld  (pr_vld),
        .lk_set  (lk_vpn_i[SET_W-1:0]),
        .lk_vpn  (lk_vpn_i),
        .lk_asid (lk_asid_i),
        .lk_any  (lk_any),
        .lk_pfn  (lk_pfn),
        .lk_perm (lk_perm)
    );

    xlat_jtlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cur_set),
        .vld_i  (vld_q),
        .take_i (take),
        .way_o  (vic_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cmd_q   <= C_NOP;
            pd0_q   <= '0;
            pd1_q   <= '0;
            idx_q   <= '0;
            hit_q   <= '0;
            vld_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (reg_wr_i) begin
                        unique case (reg_sel_i)
                            SEL_PD0: pd0_q <= reg_wdata_i;
                            SEL_PD1: pd1_q <= reg_wdata_i;
                            SEL_IDX: idx_q <= reg_wdata_i;
                            default: begin
                                cmd_q <= tlb_cmd_e'(reg_wdata_i[2:0]);
                                phase <= PH_SRCH;
                            end
                        endcase
                    end
                end
                PH_SRCH: begin
                    hit_q <= pr_hit;
                    vld_q <= pr_vld;
                    phase <= PH_DONE;
                end
                default: begin
                    phase <= PH_IDLE;
                    case (cmd_q)
                        C_PROBE: begin
                            if (hit_q == '0)
                                idx_q <= IDX_MISS;
                            else if ($countones(hit_q) > 1)
                                idx_q <= IDX_DUP;
                            else
                                idx_q <= REG_W'({cur_set, hit_way});
                        end
                        C_GETIDX:  idx_q   <= REG_W'({cur_set, vic_way});
                        C_WRITE:   flush_q <= 1'b1;
                        C_READ: begin
                            pd0_q <= pd0_pack(rd_ent);
                            pd1_q <= pd1_pack(rd_ent);
                        end
                        C_IVU:     flush_q <= 1'b1;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit_o  <= 1'b0;
            lk_pfn_o  <= '0;
            lk_perm_o <= '0;
        end else begin
            lk_hit_o  <= lk_req_i && lk_any;
            lk_pfn_o  <= lk_pfn;
            lk_perm_o <= lk_perm;
        end
    end

    assign pd0_o        = pd0_q;
    assign pd1_o        = pd1_q;
    assign index_o      = idx_q;
    assign busy_o       = (phase != PH_IDLE);
    assign utlb_flush_o = flush_q;

    // busy lasts exactly two cycles per command (R11)
    assert_busy_len_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> (busy_o ##1 !busy_o));

    // the drop pulse is a single cycle wide (R6, R10)
    assert_flush_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        utlb_flush_o |=> !utlb_flush_o);

    // a search leaves either a legal index or one of the two error codes (R3)
    assert_probe_code_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && cmd_q == C_PROBE) |=>
            (idx_q == IDX_MISS || idx_q == IDX_DUP || idx_q < 32'(ENTRIES)));

    // a lookup hit only follows a request (R12)
    assert_lookup_req_R12: assert property (@(posedge clk) disable iff (rst)
        lk_hit_o |-> $past(lk_req_i));

endmodule

// File: tb/xlat_jtlb_bench.sv
module xlat_jtlb_bench;

    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam logic [31:0] MISS = 32'h8000_0000;
    localparam logic [31:0] DUP  = 32'hC000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] pd0, pd1, index;
    logic        busy, flush;
    logic        lk_req = 1'b0;
    logic [18:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [18:0] lk_pfn;
    logic [5:0]  lk_perm;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xlat_jtlb #(.SETS(SETS), .WAYS(WAYS)) u_xlat_jtlb (
        .clk(clk), .rst(rst),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .pd0_o(pd0), .pd1_o(pd1), .index_o(index),
        .busy_o(busy), .utlb_flush_o(flush),
        .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid),
        .lk_hit_o(lk_hit), .lk_pfn_o(lk_pfn), .lk_perm_o(lk_perm)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pd0(input int vpn, input bit glb, input int asid);
        return (32'(vpn) << 13) | 32'h200 | (glb ? 32'h100 : 32'h0) | 32'(asid & 8'hFF);
    endfunction

    function automatic logic [31:0] mk_pd1(input int pfn, input int perm);
        return (32'(pfn) << 13) | 32'(perm & 6'h3F);
    endfunction

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input int c, output logic fl);
        wreg(2'd3, 32'(c));
        @(negedge clk);
        @(negedge clk);
        fl = flush;
    endtask

    task automatic look(input int vpn, input int asid);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = 19'(vpn); lk_asid = 8'(asid);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic fl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset busy", 32'(busy), 0);
        chk("R11", "reset index", index, 0);
        chk("R11", "reset pd0", pd0, 0);
        chk("R11", "reset flush", 32'(flush), 0);
        chk("R12", "reset lookup", 32'(lk_hit), 0);

        // fill every slot: search misses, slot picks lowest free way, store
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                wreg(2'd0, mk_pd0(s + SETS*(w+1), 0, s*WAYS + w + 1));
                cmd(1, fl);
                chk("R3", "fill miss", index, MISS);
                cmd(2, fl);
                chk("R4", "free slot R1", index, 32'(s*WAYS + w));
                wreg(2'd1, mk_pd1(s + SETS*(w+1) + 100, w + 1));
                cmd((w % 2 == 0) ? 3 : 4, fl);
                chk("R6", "drop pulse on store", 32'(fl), (w % 2 == 0) ? 32'd1 : 32'd0);
            end
        end

        // search every entry
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                wreg(2'd0, mk_pd0(s + SETS*(w+1), 0, s*WAYS + w + 1));
                cmd(1, fl);
                chk("R2", "search index", index, 32'(s*WAYS + w));
            end

        // read back every entry
        for (int i = 0; i < SETS*WAYS; i++) begin
            wreg(2'd2, 32'(i));
            cmd(5, fl);
            chk("R7", "read pd0", pd0, mk_pd0(i/WAYS + SETS*(i%WAYS + 1), 0, i + 1));
            chk("R7", "read pd1", pd1, mk_pd1(i/WAYS + SETS*(i%WAYS + 1) + 100, i%WAYS + 1));
        end

        // pipeline lookups, own ID hits, foreign ID misses
        for (int i = 0; i < SETS*WAYS; i++) begin
            look(i/WAYS + SETS*(i%WAYS + 1), i + 1);
            chk("R12", "lookup hit", 32'(lk_hit), 1);
            chk("R12", "lookup pfn", 32'(lk_pfn), 32'(i/WAYS + SETS*(i%WAYS + 1) + 100));
            chk("R12", "lookup perm", 32'(lk_perm), 32'(i%WAYS + 1));
            look(i/WAYS + SETS*(i%WAYS + 1), i + 101);
            chk("R9", "foreign id miss", 32'(lk_hit), 0);
        end

        // round robin in a full set, per-set pointers
        wreg(2'd0, mk_pd0(2 + SETS*9, 0, 1));
        for (int k = 0; k < 3; k++) begin
            cmd(2, fl);
            chk("R5", "round robin", index, 32'(2*WAYS + k));
        end
        wreg(2'd0, mk_pd0(3 + SETS*9, 0, 1));
        cmd(2, fl);
        chk("R5", "other set pointer", index, 32'(3*WAYS));

        // global entry at index 8
        wreg(2'd2, 32'd8);
        wreg(2'd0, mk_pd0(74, 1, 8'h55));
        wreg(2'd1, mk_pd1(500, 6'h2A));
        cmd(3, fl);
        wreg(2'd0, mk_pd0(74, 0, 8'h11));
        cmd(1, fl);
        chk("R9", "global search", index, 32'd8);
        look(74, 8'hAA);
        chk("R9", "global lookup hit", 32'(lk_hit), 1);
        chk("R9", "global lookup pfn", 32'(lk_pfn), 500);

        // duplicate at index 9
        wreg(2'd2, 32'd9);
        wreg(2'd0, mk_pd0(74, 0, 8'h11));
        wreg(2'd1, mk_pd1(600, 1));
        cmd(4, fl);
        chk("R6", "quiet store no pulse", 32'(fl), 0);
        cmd(1, fl);
        chk("R3", "duplicate code", index, DUP);
        wreg(2'd0, mk_pd0(74, 0, 8'h22));
        cmd(1, fl);
        chk("R3", "single match after dup", index, 32'd8);
        look(74, 8'h11);
        chk("R12", "lowest way wins", 32'(lk_pfn), 500);

        // drop command alone
        cmd(6, fl);
        chk("R10", "drop pulse", 32'(fl), 1);
        wreg(2'd2, 32'd9);
        cmd(5, fl);
        chk("R10", "entry kept pd0", pd0, mk_pd0(74, 0, 8'h11));
        chk("R10", "entry kept pd1", pd1, mk_pd1(600, 1));

        // writes while busy are ignored
        wreg(2'd0, mk_pd0(7 + SETS*20, 0, 3));
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'd1;
        @(negedge clk);
        chk("R11", "busy cycle 1", 32'(busy), 1);
        reg_wdata = 32'd6;
        @(negedge clk);
        chk("R11", "busy cycle 2", 32'(busy), 1);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R11", "busy released", 32'(busy), 0);
        chk("R11", "search result", index, MISS);
        chk("R11", "no pulse from dropped cmd", 32'(flush), 0);
        @(negedge clk);
        chk("R11", "dropped cmd never starts", 32'(busy), 0);
        chk("R11", "still no pulse", 32'(flush), 0);

        // blank entry at index 5
        wreg(2'd2, 32'd5);
        wreg(2'd0, 32'd0);
        wreg(2'd1, 32'd0);
        cmd(3, fl);
        wreg(2'd0, mk_pd0(1 + SETS*2, 0, 6));
        cmd(1, fl);
        chk("R8", "blank search miss", index, MISS);
        look(1 + SETS*2, 6);
        chk("R8", "blank lookup miss", 32'(lk_hit), 0);
        wreg(2'd2, 32'd5);
        cmd(5, fl);
        chk("R8", "blank read pd0", pd0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule